// File: doc/BRIEF.md
# Interrupt Coalescing Timer Unit

This block sits between one direction of a network controller's frame engine and the interrupt controller. It gathers frame-completion strobes and raises a single interrupt request only after enough frames have finished, or after a timeout has run out since the first frame that was not yet reported, whichever comes first. Software lowers the request with an acknowledge pulse.

The timeout is counted in units of 64 interface clocks. The interface clock arrives as a one-cycle tick on the system clock, and a separate enable qualifies those ticks. Because the enable is separate, the unit length in nanoseconds follows the link speed while the block's logic stays the same: 512 ns at 125 MHz, 2560 ns at 25 MHz and 25600 ns at 2.5 MHz. A 32-bit configuration word selects the mode, the frame threshold and the timeout. When coalescing is off, every completion raises the request on the next clock.

Top module: `irq_coalesce_unit`

## Requirements
- R1: After reset, irq_out is 0 and the configuration is: coalescing enabled, threshold 16 frames, timeout 4 units.
- R2: A write on cfg_wr loads the enable from bit 31, the threshold from bits 28:21 and the timeout from bits 15:0 of cfg_wdata. The new values apply from the next cycle. The write cycle clears the pending frame count and the timer, and a completion that arrives in the write cycle is discarded.
- R3: With coalescing on and irq_out low, irq_out rises on the clock edge that samples the completion which brings the pending count up to the threshold.
- R4: A threshold field of 0 behaves as a threshold of 1.
- R5: The timer runs only while coalescing is on, irq_out is low and at least one completion is pending. It starts from zero and advances one unit per 64 qualified ticks. irq_out rises on the edge that samples the qualified tick which completes the configured number of units.
- R6: An if_tick is counted only when tick_en is 1 in the same cycle.
- R7: A timeout field of 0 disables the time trigger, so only the frame threshold can raise irq_out.
- R8: Raising irq_out clears both the pending count and the timer. The completion that triggers the interrupt is absorbed into it.
- R9: With coalescing off, each completion sets irq_out on the next clock, and the pending count and timer stay cleared.
- R10: irq_ack clears irq_out on the next edge unless a new interrupt fires in that same cycle. While irq_out is high, no interrupt fires and no timer runs, but completions keep adding to the pending count. That count is checked against the threshold once irq_out is low again.
- R11: The pending count saturates at 255 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: bit 31 enable, bits 28:21 threshold, bits 15:0 timeout |
| frame_done | input | 1 | One-cycle strobe per completed frame |
| if_tick | input | 1 | One-cycle strobe per interface clock period |
| tick_en | input | 1 | Qualifies if_tick |
| irq_ack | input | 1 | Clears the interrupt request |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Every result of this block shows up on irq_out one edge after the input that causes it: the threshold completion, the qualified tick that completes the last timeout unit, a completion in pass-through mode, and an acknowledge. A completion sampled right after an acknowledge that leaves the count at or above the threshold fires one edge later still. The bench changes inputs on the falling edge, steps a behavioural model on the rising edge with the same inputs, and compares irq_out with the model on the next falling edge, so each comparison falls in the cycle in which the result is due. Directed points check the exact edge around each boundary: the 15th versus the 16th frame, and tick 255 versus tick 256.

// File: rtl/icoal_pkg.sv
package icoal_pkg;
   localparam int unsigned ICO_WORD_W = 32;
   localparam int unsigned ICO_EN_POS = 31;
   localparam int unsigned ICO_THR_LSB = 21;
   localparam int unsigned ICO_TMO_LSB = 0;

   typedef enum logic [1:0] {
      IRQ_HOLD = 2'd0,
      IRQ_SET = 2'd1,
      IRQ_CLR = 2'd2
   } irq_act_e;
endpackage

// File: rtl/icoal_cfg_reg.sv
module icoal_cfg_reg #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned CNT_W = 8,
   parameter int unsigned TMO_W = 16,
   parameter int unsigned EN_POS = 31,
   parameter int unsigned THR_LSB = 21,
   parameter int unsigned TMO_LSB = 0,
   parameter bit RST_EN = 1'b1,
   parameter int unsigned RST_THR = 16,
   parameter int unsigned RST_TMO = 4
) (
   input logic clk,
   input logic rst_n,
   input logic wr,
   input logic [WORD_W-1:0] wdata,
   output logic en,
   output logic [CNT_W-1:0] thr_eff,
   output logic [TMO_W-1:0] tmo
);
   localparam logic [CNT_W-1:0] THR_ONE = CNT_W'(1);
   logic [CNT_W-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= RST_EN;
         thr_q <= CNT_W'(RST_THR);
         tmo <= TMO_W'(RST_TMO);
      end else if (wr) begin
         en <= wdata[EN_POS];
         thr_q <= wdata[THR_LSB +: CNT_W];
         tmo <= wdata[TMO_LSB +: TMO_W];
      end
   end

   // R4: zero threshold acts as one
   always_comb thr_eff = (thr_q == '0) ? THR_ONE : thr_q;

   p_thr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      thr_eff != '0);
   p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (en == $past(wdata[EN_POS]) && tmo == $past(wdata[TMO_LSB +: TMO_W])));
endmodule

// File: rtl/icoal_pend_cnt.sv
module icoal_pend_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic clear,
   input logic inc,
   output logic [CNT_W-1:0] cnt,
   output logic nz
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (clear) cnt <= '0;
      else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   always_comb nz = (cnt != '0);

   p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !clear) |=> cnt == CNT_MAX);
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt == '0);
endmodule

// File: rtl/icoal_tmo_timer.sv
module icoal_tmo_timer #(
   parameter int unsigned TMO_W = 16,
   parameter int unsigned TICK_DIV = 64
) (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic clear,
   input logic tick,
   input logic [TMO_W-1:0] tmo,
   output logic hit
);
   logic unit_step;
   logic [TMO_W-1:0] units;

   generate
      if (TICK_DIV == 1) begin : g_direct
         always_comb unit_step = run && tick;
      end else begin : g_prescale
         localparam int unsigned PRE_W = $clog2(TICK_DIV);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
         logic [PRE_W-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre <= '0;
            else if (!run || clear) pre <= '0;
            else if (tick) pre <= pre + 1'b1;
         end
         always_comb unit_step = run && tick && (pre == PRE_LAST);
         p_pre_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> pre == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) units <= '0;
      else if (!run || clear) units <= '0;
      else if (unit_step) units <= units + 1'b1;
   end

   // R7: zero timeout never hits
   always_comb hit = unit_step && (tmo != '0) && (units == tmo - 1'b1);

   p_units_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> units == '0);
   p_zero_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo == '0) |-> !hit);
endmodule

// File: rtl/irq_coalesce_unit.sv
module irq_coalesce_unit #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned TMO_W = 16,
   parameter int unsigned TICK_DIV = 64,
   parameter bit RST_EN = 1'b1,
   parameter int unsigned RST_THR = 16,
   parameter int unsigned RST_TMO = 4
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_wr,
   input logic [31:0] cfg_wdata,
   input logic frame_done,
   input logic if_tick,
   input logic tick_en,
   input logic irq_ack,
   output logic irq_out
);
   import icoal_pkg::*;

   generate
      if (TICK_DIV == 0 || (TICK_DIV & (TICK_DIV - 1)) != 0) begin : g_bad_div
         $error("TICK_DIV must be a power of two");
      end
      if (ICO_THR_LSB + CNT_W > ICO_EN_POS || ICO_TMO_LSB + TMO_W > ICO_THR_LSB) begin : g_bad_fields
         $error("configuration fields overlap");
      end
   endgenerate

   logic en;
   logic [CNT_W-1:0] thr_eff;
   logic [TMO_W-1:0] tmo;
   logic [CNT_W-1:0] cnt;
   logic cnt_nz;
   logic t_run, t_hit, fire, cnt_clear;
   logic [CNT_W:0] cnt_plus;
   irq_act_e act;

   icoal_cfg_reg #(
      .WORD_W(ICO_WORD_W), .CNT_W(CNT_W), .TMO_W(TMO_W),
      .EN_POS(ICO_EN_POS), .THR_LSB(ICO_THR_LSB), .TMO_LSB(ICO_TMO_LSB),
      .RST_EN(RST_EN), .RST_THR(RST_THR), .RST_TMO(RST_TMO)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .en(en), .thr_eff(thr_eff), .tmo(tmo)
   );

   icoal_pend_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .inc(frame_done),
      .cnt(cnt), .nz(cnt_nz)
   );

   icoal_tmo_timer #(.TMO_W(TMO_W), .TICK_DIV(TICK_DIV)) i_tmr (
      .clk(clk), .rst_n(rst_n), .run(t_run), .clear(fire),
      .tick(if_tick && tick_en), .tmo(tmo), .hit(t_hit)
   );

   always_comb begin
      cnt_plus = {1'b0, cnt} + (CNT_W+1)'(frame_done);
      t_run = en && !irq_out && cnt_nz && !cfg_wr;
      fire = en && !irq_out && !cfg_wr &&
             ((cnt_plus >= {1'b0, thr_eff}) || t_hit);
      cnt_clear = fire || cfg_wr || !en;
      act = IRQ_HOLD;
      if (!cfg_wr && ((!en && frame_done) || fire)) act = IRQ_SET;
      else if (irq_ack) act = IRQ_CLR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= 1'b0;
      else begin
         case (act)
            IRQ_SET: irq_out <= 1'b1;
            IRQ_CLR: irq_out <= 1'b0;
            default: irq_out <= irq_out;
         endcase
      end
   end

   p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && frame_done && !cfg_wr) |=> irq_out);
   p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && irq_ack && !frame_done) |=> !irq_out);
   p_rise_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> cnt == '0);
   p_thr_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !irq_out && !cfg_wr && frame_done && cnt_plus >= {1'b0, thr_eff}) |=> irq_out);
   p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cnt == '0);
endmodule

// File: tb/test_irq_coalesce_unit.sv
`timescale 1ns/1ps
module test_irq_coalesce_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic frame_done = 1'b0, if_tick = 1'b0, tick_en = 1'b0, irq_ack = 1'b0;
   logic irq_out;

   int checks = 0, failures = 0, cycles = 0;
   string phase = "R1";

   // reference model state
   bit m_en, m_irq;
   int m_thr, m_tmo, m_cnt, m_ticks;

   always #2 clk = ~clk;

   irq_coalesce_unit i_irq_coalesce_unit (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .frame_done(frame_done), .if_tick(if_tick), .tick_en(tick_en),
      .irq_ack(irq_ack), .irq_out(irq_out)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 1; m_thr = 16; m_tmo = 4; m_irq = 0; m_cnt = 0; m_ticks = 0;
      end else begin
         bit nirq, run, fire;
         int c, t, th;
         nirq = irq_ack ? 1'b0 : m_irq;
         if (cfg_wr) begin
            m_en = cfg_wdata[31]; m_thr = cfg_wdata[28:21]; m_tmo = cfg_wdata[15:0];
            m_cnt = 0; m_ticks = 0;
         end else if (!m_en) begin
            if (frame_done) nirq = 1;
            m_cnt = 0; m_ticks = 0;
         end else begin
            th = (m_thr == 0) ? 1 : m_thr;
            c = m_cnt + (frame_done ? 1 : 0);
            if (c > 255) c = 255;
            run = !m_irq && m_cnt > 0;
            t = m_ticks + ((run && if_tick && tick_en) ? 1 : 0);
            fire = !m_irq && (c >= th || (m_tmo != 0 && run && t >= 64 * m_tmo));
            if (fire) begin
               nirq = 1; m_cnt = 0; m_ticks = 0;
            end else begin
               m_cnt = c; m_ticks = run ? t : 0;
            end
         end
         m_irq = nirq;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (irq_out !== m_irq) begin
            failures++;
            $display("FAIL %s model compare: irq_out=%0b expected=%0b at t=%0t", phase, irq_out, m_irq, $time);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic step(input bit fd, input bit tk, input bit ce, input bit ak);
      frame_done = fd; if_tick = tk; tick_en = ce; irq_ack = ak;
      @(negedge clk);
      frame_done = 0; if_tick = 0; tick_en = 0; irq_ack = 0;
   endtask

   task automatic write_cfg(input bit en, input int thr, input int tmo, input bit fd);
      cfg_wr = 1; cfg_wdata = {en, 2'b00, 8'(thr), 5'd0, 16'(tmo)};
      step(fd, 0, 0, 0);
      cfg_wr = 0;
   endtask

   task automatic expect_irq(input bit exp, input string req);
      checks++;
      if (irq_out !== exp) begin
         failures++;
         $display("FAIL %s: irq_out=%0b expected=%0b at t=%0t", req, irq_out, exp, $time);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      expect_irq(0, "R1 reset");
      // R1: default threshold 16
      for (int i = 0; i < 15; i++) step(1, 0, 0, 0);
      expect_irq(0, "R1 after 15 frames");
      phase = "R3";
      step(1, 0, 0, 0);
      expect_irq(1, "R3 16th frame fires");
      step(0, 0, 0, 1);
      expect_irq(0, "R10 ack clears");
      // R5: default timeout 4 units = 256 ticks
      phase = "R5";
      step(1, 0, 0, 0);
      for (int i = 0; i < 255; i++) step(0, 1, 1, 0);
      expect_irq(0, "R5 tick 255");
      step(0, 1, 1, 0);
      expect_irq(1, "R5 tick 256 fires");
      step(0, 0, 0, 1);
      // R6: unqualified ticks ignored
      phase = "R6";
      write_cfg(1, 200, 1, 0);
      step(1, 0, 0, 0);
      for (int i = 0; i < 100; i++) step(0, 1, 0, 0);
      for (int i = 0; i < 63; i++) step(0, 1, 1, 0);
      expect_irq(0, "R6 ticks without enable ignored");
      step(0, 1, 1, 0);
      expect_irq(1, "R6 64th qualified tick fires");
      step(0, 0, 0, 1);
      // R7: timeout 0
      phase = "R7";
      write_cfg(1, 200, 0, 0);
      step(1, 0, 0, 0);
      for (int i = 0; i < 500; i++) step(0, 1, 1, 0);
      expect_irq(0, "R7 zero timeout never fires");
      // R4: threshold 0
      phase = "R4";
      write_cfg(1, 0, 0, 0);
      step(1, 0, 0, 0);
      expect_irq(1, "R4 zero threshold acts as one");
      step(0, 0, 0, 1);
      // R2 and R8 with threshold 3
      phase = "R2";
      write_cfg(1, 3, 0, 0);
      step(1, 0, 0, 0); step(1, 0, 0, 0);
      write_cfg(1, 3, 0, 1);
      step(1, 0, 0, 0); step(1, 0, 0, 0);
      expect_irq(0, "R2 write clears count and drops its completion");
      step(1, 0, 0, 0);
      expect_irq(1, "R2 new count reaches threshold");
      phase = "R8";
      step(0, 0, 0, 1);
      step(1, 0, 0, 0); step(1, 0, 0, 0);
      expect_irq(0, "R8 count cleared by fire");
      step(1, 0, 0, 0);
      expect_irq(1, "R8 fires again at threshold");
      // R10: ack and completion together while irq high
      phase = "R10";
      write_cfg(1, 1, 0, 0);
      step(1, 1, 1, 1);
      expect_irq(0, "R10 ack lowers irq, no fire while high");
      step(0, 0, 0, 0);
      expect_irq(1, "R10 held completion fires after ack");
      // R11: saturation, irq high during accumulation
      phase = "R11";
      write_cfg(1, 255, 0, 0);
      for (int i = 0; i < 300; i++) step(1, 0, 0, 0);
      expect_irq(1, "R11 irq held high");
      step(0, 0, 0, 1);
      expect_irq(0, "R11 ack");
      step(0, 0, 0, 0);
      expect_irq(1, "R11 saturated count 255 fires");
      step(0, 0, 0, 1);
      // R9: pass-through
      phase = "R9";
      write_cfg(0, 5, 1, 0);
      step(1, 0, 0, 0);
      expect_irq(1, "R9 completion passes through");
      step(1, 0, 0, 1);
      expect_irq(1, "R9 completion beats ack");
      step(0, 0, 0, 1);
      for (int i = 0; i < 5; i++) step(0, 1, 1, 0);
      expect_irq(0, "R9 no completion no irq");
      // mixed random traffic against the model
      phase = "R3/R5 random";
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 199) == 0)
            write_cfg($urandom_range(0, 5) != 0, $urandom_range(0, 8), $urandom_range(0, 3), $urandom_range(0, 1));
         else
            step($urandom_range(0, 5) == 0, $urandom_range(0, 1), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 9) == 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule